// File: doc/BRIEF.md
# Sixteen-Bit Timer with Dual Compare, Input Capture and Up-Down PWM

This block is a 16-bit timer/counter. It advances only on cycles where an external prescaler raises its `tick` input. In free-running mode it counts upward and wraps. It has two output-compare channels. Each channel raises its own flag on a match and drives its own output pin. A capture unit watches an external event pin. When the selected edge arrives, it copies the counter into a capture register and raises a capture flag. An optional filter rejects short glitches on that pin.

In PWM mode the counter sweeps up and down between zero and a top value of 8, 9 or 10 bits. Each compare pin clears on a match while the counter rises and sets on a match while it falls. New compare values are held in a buffer and take effect only when the counter turns around at top, so a period never sees a partial update.

Software reaches six registers through a flat write/read port. The read path is combinational. Address 0 is control, 1 is the counter, 2 is compare A, 3 is compare B, 4 is the read-only capture register and 5 holds the flags.

Top module: `timer16_cmp_cap`

The counter sequencer has three states:
- `ST_FREE`: wrap-around up count.
- `ST_RISE`: counting up in PWM mode.
- `ST_FALL`: counting down in PWM mode.

Its transitions are:
- `FREE->RISE`: when a PWM mode is selected.
- `RISE->FALL`: on a tick at or above top.
- `FALL->RISE`: on a tick at zero.
- any state `->FREE`: when the mode field returns to 0.

## Requirements
- R1: After reset, every readable register (addresses 0 to 5), every flag output and both compare pins are zero.
- R2: With control bits [1:0] = 0, the counter rises by one on each cycle with `tick` high and holds otherwise. A tick at 0xFFFF wraps it to 0 and sets the overflow flag (flag bit 0).
- R3: On a counting cycle where the counter equals the active compare A (B) value, flag bit 1 (bit 2) sets on the next edge. In free-running mode the matching pin toggles.
- R4: Control bits [1:0] = 1, 2, 3 select PWM with top 0x00FF, 0x01FF, 0x03FF. A tick at or above top steps the count down and reverses direction. A tick at zero while falling steps the count to 1, reverses direction and sets the overflow flag.
- R5: In PWM mode, a compare match while rising drives that pin to 0, and a match while falling drives it to 1.
- R6: In PWM mode, compare writes go to a buffer, which reads back at once. The active value loads from the buffer on the turnaround tick at top. In free-running mode, writes take effect immediately.
- R7: Control bit 2 selects the capture edge: 1 for rising, 0 for falling. The pin passes two synchronizer stages and one level stage, and the capture unit sees an edge between consecutive level values. On that edge the current count is copied to the capture register (address 4) and flag bit 3 sets.
- R8: With control bit 3 set, the level stage changes only after four consecutive equal synchronized samples. Shorter pulses cause no capture.
- R9: Writing to address 5 clears each flag whose data bit is 1. A flag being set in the same cycle stays set.
- R10: A write to the counter (address 1) loads it on the next edge, overrides any tick in that cycle, and raises no event in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable from prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| cap_pin | input | 1 | External capture event pin |
| oc_a | output | 1 | Compare A / PWM output |
| oc_b | output | 1 | Compare B / PWM output |
| irq_ovf | output | 1 | Overflow flag |
| irq_cmp_a | output | 1 | Compare A flag |
| irq_cmp_b | output | 1 | Compare B flag |
| irq_cap | output | 1 | Capture flag |

## Verification
The collision of interest is a flag being raised by a compare match in the same cycle that software writes a 1 to clear it. The bench loads the counter just below compare A. It then ticks it into the match and issues the clear on exactly the match cycle, and expects the flag to survive. A second collision loads the counter in a cycle where a tick is also high, and expects the written value with no event from that cycle. Both are judged by a cycle-by-cycle behavioural model that compares every flag, pin and the addressed register on each clock.

// File: rtl/timer16_pkg.sv
package timer16_pkg;
    parameter int CNT_W  = 16;
    parameter int ADDR_W = 3;
    parameter int FLT_N  = 4;
    parameter int NCH    = 2;

    typedef enum logic [1:0] {ST_FREE = 2'd0, ST_RISE = 2'd1, ST_FALL = 2'd2} seq_e;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMPA  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMPB  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CAPT  = 3'd4;
    localparam logic [ADDR_W-1:0] A_FLAGS = 3'd5;

    function automatic logic [CNT_W-1:0] top_of(input logic [1:0] mode);
        case (mode)
            2'd1:    top_of = CNT_W'(16'h00FF);
            2'd2:    top_of = CNT_W'(16'h01FF);
            default: top_of = CNT_W'(16'h03FF);
        endcase
    endfunction
endpackage

// File: rtl/timer16_seq.sv
module timer16_seq
    import timer16_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [1:0]   mode,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    output logic [W-1:0] cnt_o,
    output logic         falling_o,
    output logic         step_o,
    output logic         ovf_evt_o,
    output logic         top_evt_o
);
    localparam logic [W-1:0] ALL1 = {W{1'b1}};
    localparam logic [W-1:0] ONE  = W'(1);

    seq_e         st_q, st_eff, st_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic [W-1:0] top;

    assign top = top_of(mode);

    // state as seen this cycle: mode selects family, FREE enters RISE
    always_comb begin
        if (mode == 2'd0)          st_eff = ST_FREE;
        else if (st_q == ST_FREE)  st_eff = ST_RISE;
        else                       st_eff = st_q;
    end

    always_comb begin
        st_d      = st_eff;
        cnt_d     = cnt_q;
        ovf_evt_o = 1'b0;
        top_evt_o = 1'b0;
        if (cnt_wr) begin
            cnt_d = cnt_wdata;
        end else if (tick) begin
            unique case (st_eff)
                ST_FREE: begin
                    cnt_d     = cnt_q + ONE;
                    ovf_evt_o = (cnt_q == ALL1);
                end
                ST_RISE: begin
                    if (cnt_q >= top) begin
                        cnt_d     = cnt_q - ONE;
                        st_d      = ST_FALL;
                        top_evt_o = 1'b1;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                ST_FALL: begin
                    if (cnt_q == '0) begin
                        cnt_d     = ONE;
                        st_d      = ST_RISE;
                        ovf_evt_o = 1'b1;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                default: cnt_d = cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_FREE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o     = cnt_q;
    assign falling_o = (st_eff == ST_FALL);
    assign step_o    = tick && !cnt_wr;
endmodule

// File: rtl/timer16_cmp_ch.sv
module timer16_cmp_ch
    import timer16_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         step,
    input  logic         top_evt,
    input  logic         falling,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] buf_o,
    output logic         match_o,
    output logic         pin_o
);
    logic [W-1:0] buf_q, act_q;
    logic         pin_q;

    assign match_o = step && (cnt == act_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
            act_q <= '0;
            pin_q <= 1'b0;
        end else begin
            if (wr) buf_q <= wdata;
            if (wr && mode == 2'd0)           act_q <= wdata;
            else if (mode != 2'd0 && top_evt) act_q <= buf_q;
            if (match_o) begin
                if (mode == 2'd0) pin_q <= ~pin_q;
                else              pin_q <= falling;
            end
        end
    end

    assign buf_o = buf_q;
    assign pin_o = pin_q;
endmodule

// File: rtl/timer16_capture.sv
module timer16_capture
    import timer16_pkg::*;
#(
    parameter int W    = CNT_W,
    parameter int NFLT = FLT_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pin,
    input  logic         rise_sel,
    input  logic         filt_en,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] capt_o,
    output logic         evt_o
);
    localparam logic [NFLT-1:0] HI = {NFLT{1'b1}};

    logic            s1_q, s2_q, lvl_q, lvl_d_q;
    logic [NFLT-1:0] hist_q;
    logic [W-1:0]    capt_q;

    assign evt_o = rise_sel ? (lvl_q && !lvl_d_q) : (!lvl_q && lvl_d_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q    <= 1'b0;
            s2_q    <= 1'b0;
            hist_q  <= '0;
            lvl_q   <= 1'b0;
            lvl_d_q <= 1'b0;
            capt_q  <= '0;
        end else begin
            s1_q    <= pin;
            s2_q    <= s1_q;
            hist_q  <= {hist_q[NFLT-2:0], s2_q};
            lvl_d_q <= lvl_q;
            if (!filt_en)            lvl_q <= s2_q;
            else if (hist_q == HI)   lvl_q <= 1'b1;
            else if (hist_q == '0)   lvl_q <= 1'b0;
            if (evt_o) capt_q <= cnt;
        end
    end

    assign capt_o = capt_q;
endmodule

// File: rtl/timer16_cmp_cap.sv
module timer16_cmp_cap
    import timer16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  logic              cap_pin,
    output logic              oc_a,
    output logic              oc_b,
    output logic              irq_ovf,
    output logic              irq_cmp_a,
    output logic              irq_cmp_b,
    output logic              irq_cap
);
    localparam int NFLAG = 2 + NCH;

    logic [3:0]       ctrl_q;
    logic [NFLAG-1:0] flags_q, flag_set, flag_clr;
    logic [CNT_W-1:0] cnt_q, capt;
    logic             falling, step, ovf_evt, top_evt, cap_evt;
    logic [CNT_W-1:0] ch_buf [NCH];
    logic [NCH-1:0]   ch_match, ch_pin;

    timer16_seq #(.W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(ctrl_q[1:0]),
        .cnt_wr(wr_en && wr_addr == A_COUNT), .cnt_wdata(wr_data),
        .cnt_o(cnt_q), .falling_o(falling), .step_o(step),
        .ovf_evt_o(ovf_evt), .top_evt_o(top_evt)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        timer16_cmp_ch #(.W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .mode(ctrl_q[1:0]),
            .wr(wr_en && wr_addr == A_CMPA + ADDR_W'(g)), .wdata(wr_data),
            .step(step), .top_evt(top_evt), .falling(falling), .cnt(cnt_q),
            .buf_o(ch_buf[g]), .match_o(ch_match[g]), .pin_o(ch_pin[g])
        );
    end

    timer16_capture #(.W(CNT_W), .NFLT(FLT_N)) u_cap (
        .clk(clk), .rst_n(rst_n), .pin(cap_pin), .rise_sel(ctrl_q[2]),
        .filt_en(ctrl_q[3]), .cnt(cnt_q), .capt_o(capt), .evt_o(cap_evt)
    );

    assign flag_set = {cap_evt, ch_match, ovf_evt};
    assign flag_clr = (wr_en && wr_addr == A_FLAGS) ? wr_data[NFLAG-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            flags_q <= '0;
        end else begin
            if (wr_en && wr_addr == A_CTRL) ctrl_q <= wr_data[3:0];
            flags_q <= (flags_q & ~flag_clr) | flag_set;
        end
    end

    always_comb begin
        unique case (rd_addr)
            A_CTRL:  rd_data = CNT_W'(ctrl_q);
            A_COUNT: rd_data = cnt_q;
            A_CMPA:  rd_data = ch_buf[0];
            A_CMPB:  rd_data = ch_buf[1];
            A_CAPT:  rd_data = capt;
            A_FLAGS: rd_data = CNT_W'(flags_q);
            default: rd_data = '0;
        endcase
    end

    assign oc_a      = ch_pin[0];
    assign oc_b      = ch_pin[1];
    assign irq_ovf   = flags_q[0];
    assign irq_cmp_a = flags_q[1];
    assign irq_cmp_b = flags_q[2];
    assign irq_cap   = flags_q[3];
endmodule

// File: rtl/timer16_cmp_cap_chk.sv
module timer16_cmp_cap_chk
    import timer16_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  wr_data,
    input logic [3:0]        ctrl_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              falling,
    input logic              irq_ovf
);
    logic cwr;
    assign cwr = wr_en && wr_addr == A_COUNT;

    // R2
    free_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[1:0] == 2'd0 && tick && !cwr) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cwr) |=> $stable(cnt_q));

    // R10
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cwr |=> cnt_q == $past(wr_data));

    // R4
    bottom_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[1:0] != 2'd0 && falling && tick && !cwr && cnt_q == '0) |=> irq_ovf);
endmodule

bind timer16_cmp_cap timer16_cmp_cap_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_q(ctrl_q), .cnt_q(cnt_q), .falling(falling),
    .irq_ovf(irq_ovf)
);

// File: tb/timer16_cmp_cap_tb.sv
module timer16_cmp_cap_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, wr_en = 1'b0, cap_pin = 1'b0;
    logic [2:0]  wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        oc_a, oc_b, irq_ovf, irq_cmp_a, irq_cmp_b, irq_cap;

    int n_chk = 0, n_bad = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    timer16_cmp_cap dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cap_pin(cap_pin),
        .oc_a(oc_a), .oc_b(oc_b), .irq_ovf(irq_ovf), .irq_cmp_a(irq_cmp_a),
        .irq_cmp_b(irq_cmp_b), .irq_cap(irq_cap)
    );

    // behavioural reference model
    logic [15:0] m_cnt, m_capt, m_buf[2], m_act[2];
    logic [3:0]  m_ctrl, m_flags, m_hist;
    logic [1:0]  m_pin;
    int          m_dir;  // 0 free, 1 up, 2 down
    logic        m_s1, m_s2, m_lvl, m_lvld;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_capt = 0; m_buf[0] = 0; m_buf[1] = 0; m_act[0] = 0; m_act[1] = 0;
            m_ctrl = 0; m_flags = 0; m_hist = 0; m_pin = 0; m_dir = 0;
            m_s1 = 0; m_s2 = 0; m_lvl = 0; m_lvld = 0;
        end else begin
            logic [1:0]  md;
            logic [15:0] top, n_cnt;
            int          dir, n_dir;
            logic        ovf, topev, stp, edge_ev, n_lvl;
            logic [1:0]  mt;
            logic [3:0]  clr;
            md  = m_ctrl[1:0];
            top = (md == 1) ? 16'h00FF : (md == 2) ? 16'h01FF : 16'h03FF;
            dir = (md == 0) ? 0 : (m_dir == 0 ? 1 : m_dir);
            n_cnt = m_cnt; n_dir = dir; ovf = 0; topev = 0;
            stp = tick && !(wr_en && wr_addr == 1);
            if (wr_en && wr_addr == 1) n_cnt = wr_data;
            else if (tick) begin
                if (dir == 0) begin n_cnt = m_cnt + 1; ovf = (m_cnt == 16'hFFFF); end
                else if (dir == 1) begin
                    if (m_cnt >= top) begin n_cnt = m_cnt - 1; n_dir = 2; topev = 1; end
                    else n_cnt = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin n_cnt = 1; n_dir = 1; ovf = 1; end
                    else n_cnt = m_cnt - 1;
                end
            end
            for (int c = 0; c < 2; c++) begin
                mt[c] = stp && (m_cnt == m_act[c]);
                if (mt[c]) m_pin[c] = (md == 0) ? ~m_pin[c] : (dir == 2);
                if (wr_en && wr_addr == 3'(2 + c) && md == 0) m_act[c] = wr_data;
                else if (md != 0 && topev) m_act[c] = m_buf[c];
                if (wr_en && wr_addr == 3'(2 + c)) m_buf[c] = wr_data;
            end
            edge_ev = m_ctrl[2] ? (m_lvl && !m_lvld) : (!m_lvl && m_lvld);
            if (edge_ev) m_capt = m_cnt;
            n_lvl = m_lvl;
            if (!m_ctrl[3]) n_lvl = m_s2;
            else if (m_hist == 4'hF) n_lvl = 1;
            else if (m_hist == 4'h0) n_lvl = 0;
            m_lvld = m_lvl; m_lvl = n_lvl;
            m_hist = {m_hist[2:0], m_s2};
            m_s2 = m_s1; m_s1 = cap_pin;
            clr = (wr_en && wr_addr == 5) ? wr_data[3:0] : 4'h0;
            m_flags = (m_flags & ~clr) | {edge_ev, mt[1], mt[0], ovf};
            if (wr_en && wr_addr == 0) m_ctrl = wr_data[3:0];
            m_cnt = n_cnt; m_dir = n_dir;
        end
    end

    function automatic logic [15:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: m_read = {12'h0, m_ctrl};
            3'd1: m_read = m_cnt;
            3'd2: m_read = m_buf[0];
            3'd3: m_read = m_buf[1];
            3'd4: m_read = m_capt;
            3'd5: m_read = {12'h0, m_flags};
            default: m_read = 16'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        string t;
        case (rd_addr)
            3'd0: t = "R4 ctrl";  3'd1: t = "R2 count"; 3'd2, 3'd3: t = "R6 cmpbuf";
            3'd4: t = "R7 capt";  default: t = "R9 flags";
        endcase
        chk(t, rd_data, m_read(rd_addr));
        chk("R2/R4 ovf flag", {15'h0, irq_ovf}, {15'h0, m_flags[0]});
        chk("R3 cmpA flag", {15'h0, irq_cmp_a}, {15'h0, m_flags[1]});
        chk("R3 cmpB flag", {15'h0, irq_cmp_b}, {15'h0, m_flags[2]});
        chk("R7 cap flag", {15'h0, irq_cap}, {15'h0, m_flags[3]});
        chk("R5 pin A", {15'h0, oc_a}, {15'h0, m_pin[0]});
        chk("R5 pin B", {15'h0, oc_b}, {15'h0, m_pin[1]});
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        compare_all();
        rd_addr = (rd_addr == 3'd5) ? 3'd0 : rd_addr + 3'd1;
    endtask

    task automatic wreg(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
    endtask

    task automatic run(input int n, input int dense);
        for (int i = 0; i < n; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tick = dense ? 1'b1 : (lfsr[1:0] != 2'b00);
            cyc();
        end
        tick = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, input string tag, input logic [15:0] exp);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        for (int a = 0; a < 6; a++) peek(3'(a), "R1 reset reg", 16'h0);
        chk("R1 reset pins", {14'h0, oc_a, oc_b}, 16'h0);
        rst_n = 1'b1;
        cyc();
        // free mode with compares and sparse ticks
        wreg(3'd2, 16'd5);
        wreg(3'd3, 16'd9);
        run(60, 0);
        // wrap
        wreg(3'd1, 16'hFFF8);
        run(20, 1);
        wreg(3'd5, 16'hF);
        // load with tick high (R10), then clear collides with A match (R9)
        tick = 1'b1;
        wreg(3'd1, 16'd4);
        peek(3'd1, "R10 count load", 16'd4);
        cyc();
        wr_en = 1'b1; wr_addr = 3'd5; wr_data = 16'h2;
        cyc();
        tick = 1'b0;
        chk("R9 set beats clear", {15'h0, irq_cmp_a}, 16'h1);
        wreg(3'd5, 16'hF);
        chk("R9 clear", {12'h0, irq_ovf, irq_cmp_a, irq_cmp_b, irq_cap}, 16'h0);
        // capture rising, then falling
        wreg(3'd0, 16'h4);
        run(5, 1);
        cap_pin = 1'b1;
        run(8, 0);
        peek(3'd5, "R7 rising capture", {12'h0, m_flags});
        chk("R7 rising flag", {15'h0, irq_cap}, 16'h1);
        wreg(3'd5, 16'h8);
        wreg(3'd0, 16'h0);
        cap_pin = 1'b0;
        run(8, 1);
        chk("R7 falling flag", {15'h0, irq_cap}, 16'h1);
        wreg(3'd5, 16'hF);
        // noise filter: short glitch ignored, long pulse accepted
        wreg(3'd0, 16'hC);
        run(8, 1);
        cap_pin = 1'b1; run(3, 1); cap_pin = 1'b0;
        run(12, 1);
        chk("R8 glitch rejected", {15'h0, irq_cap}, 16'h0);
        cap_pin = 1'b1;
        run(12, 1);
        chk("R8 long pulse captured", {15'h0, irq_cap}, 16'h1);
        wreg(3'd5, 16'hF);
        // PWM 8-bit with mid-period buffer update
        wreg(3'd1, 16'h0);
        wreg(3'd2, 16'h0040);
        wreg(3'd3, 16'h00C0);
        wreg(3'd0, 16'h1);
        run(300, 1);
        wreg(3'd2, 16'h0080);
        peek(3'd2, "R6 buffer readback", 16'h0080);
        run(900, 0);
        // PWM 9-bit and 10-bit
        wreg(3'd0, 16'h2);
        run(1200, 1);
        wreg(3'd3, 16'h0300);
        wreg(3'd0, 16'h3);
        run(2300, 1);
        chk("R4 bottom overflow seen", {15'h0, irq_ovf}, 16'h1);
        wreg(3'd0, 16'h0);
        run(40, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule